// File: doc/BRIEF.md
# Multiplierless 8-Point DCT Engine

This block takes eight signed 8-bit samples and produces their eight one-dimensional DCT coefficients. It has no hardware multiplier. An even/odd butterfly first reduces the samples to eight intermediate terms: two full sums, four mirrored differences and two mixed terms. Each coefficient is then an inner product of up to four of those terms with fixed cosine constants. The inner product is formed by distributed arithmetic. A per-coefficient table holds every signed sum of that coefficient's constants. A shift-accumulator walks the terms one bit position per clock, least significant bit first, and subtracts the table value on the sign-bit cycle.

A host drives the eight samples in parallel and pulses `start`. Eleven bit cycles later, plus one capture cycle, the rounded coefficients appear together with a one-cycle `done` pulse. They stay unchanged until the next accepted request finishes. Row/column transposition, quantisation and the inverse transform belong to neighbouring blocks.

Top module: `dct8_da`

## Requirements
- R1: Sample n is `samples[n*8 +: 8]` (two's complement), and coefficient k is `coefs[k*11 +: 11]` (two's complement). With S the sum of all eight samples and P = ½cos(π/4), coefficient 0 equals round(S·P) within ±1.
- R2: Coefficient 4 equals round(P·(x0−x1−x2+x3+x4−x5−x6+x7)) within ±1.
- R3: With u = x0−x3−x4+x7, v = x1−x2−x5+x6, M = ½cos(π/8) and N = ½cos(3π/8), coefficient 2 equals round(u·M+v·N) and coefficient 6 equals round(u·N−v·M), each within ±1.
- R4: With d1..d4 = x0−x7, x1−x6, x2−x5, x3−x4 and A, B, C, D = ½cos of π/16, 3π/16, 5π/16 and 7π/16, the odd coefficients 1, 3, 5 and 7 equal the rounded values of d1·A+d2·B+d3·C+d4·D, d1·B−d2·D−d3·A−d4·C, d1·C−d2·A+d3·D+d4·B and d1·D−d2·C+d3·B−d4·A, each within ±1.
- R5: `start` is sampled on a rising clock edge when the engine is idle. `done` is high for exactly one cycle, beginning 12 clock edges after that sampling edge.
- R6: Between two `done` pulses, `coefs` does not change, whatever happens on `samples`.
- R7: A `start` sampled while a transform is in progress has no effect. It produces no extra `done`, and it changes neither the timing nor the values of the running result.
- R8: While reset (`rstN` low) is applied and afterwards until the first `done`, `done` is low and `coefs` is zero.
- R9: Full-scale inputs (all −128, all +127 and alternating +127/−128) give results within ±1 of the rounded values above, so the sign-bit subtraction is exact for two's-complement terms.
- R10: A `start` presented in the cycle where `done` is high is accepted. Its result arrives 12 edges later with no idle gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, accepted when idle |
| samples | input | 64 | Eight signed 8-bit samples, sample n at bits n*8 +: 8 |
| done | output | 1 | One-cycle pulse when coefficients are updated |
| coefs | output | 88 | Eight signed 11-bit coefficients, coefficient k at bits k*11 +: 11 |

## Verification
Every coefficient of a request becomes due together with `done`, exactly 12 rising edges after the edge that accepted `start`. The driver reads a free-running edge counter at the falling edge after the accepting edge and queues the due count with the stimulus. The monitor samples only at falling edges. When it sees `done`, it pops the oldest entry and checks the edge count and all eight coefficients against a double-precision cosine model. It also checks that no `done` arrives without a queued request, which catches an ignored `start` that was not actually ignored. Hold and back-to-back cases are timed from the falling edge at which `done` is observed.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

  localparam int NPT     = 8;
  localparam int LANE_IN = 4;

  typedef struct packed {
    logic load;
    logic step;
    logic lastBit;
    logic capture;
  } dct8_ctl_t;

  // Butterfly term slots: 0 full sum, 1 alternating sum, 2..5 mirrored
  // differences, 6..7 mixed terms.
  function automatic int laneTerm(int k, int j);
    case (k)
      0:       return 0;
      4:       return 1;
      2, 6:    return (j == 0) ? 6 : 7;
      default: return 2 + j;
    endcase
  endfunction

  // Constant codes: 1 P, 2 M, 3 N, 4 A, 5 B, 6 C, 7 D; negative means minus.
  function automatic int laneConst(int k, int j);
    int odd1[LANE_IN] = '{4, 5, 6, 7};
    int odd3[LANE_IN] = '{5, -7, -4, -6};
    int odd5[LANE_IN] = '{6, -4, 7, 5};
    int odd7[LANE_IN] = '{7, -6, 5, -4};
    case (k)
      0, 4:    return (j == 0) ? 1 : 0;
      2:       return (j == 0) ? 2 : ((j == 1) ? 3 : 0);
      6:       return (j == 0) ? 3 : ((j == 1) ? -2 : 0);
      1:       return odd1[j];
      3:       return odd3[j];
      5:       return odd5[j];
      default: return odd7[j];
    endcase
  endfunction

endpackage

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
  import dct8_pkg::*;
#(
  parameter int TERM_W = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output dct8_ctl_t ctl,
  output logic      done
);

  localparam int CNT_W = $clog2(TERM_W);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_CAPT} state_t;

  state_t           state;
  logic [CNT_W-1:0] bitCnt;

  always_comb begin
    ctl = '0;
    case (state)
      ST_IDLE: ctl.load = start;
      ST_RUN: begin
        ctl.step    = 1'b1;
        ctl.lastBit = (bitCnt == CNT_W'(TERM_W - 1));
      end
      ST_CAPT: ctl.capture = 1'b1;
      default: ctl = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctl.capture;
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_RUN;
          bitCnt <= '0;
        end
        ST_RUN: begin
          bitCnt <= bitCnt + 1'b1;
          if (ctl.lastBit) state <= ST_CAPT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dct8_datapath.sv
module dct8_datapath
  import dct8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TERM_W = DATA_W + 3,
  parameter int FRAC_W = 12,
  parameter int OUT_W  = TERM_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dct8_ctl_t               ctl,
  input  logic [NPT*DATA_W-1:0]   samples,
  output logic [NPT*OUT_W-1:0]    coefs
);

  localparam int ROM_W = FRAC_W + 4;
  localparam int ACC_W = FRAC_W + TERM_W + 4;
  localparam int ROM_N = 1 << LANE_IN;
  localparam logic signed [ACC_W-1:0] ROUND_ADD = ACC_W'(1) <<< (FRAC_W - 1);

  function automatic int qConst(int code);
    real c;
    int  mag;
    mag = (code < 0) ? -code : code;
    case (mag)
      1:       c = 0.70710678118654752;
      2:       c = 0.92387953251128676;
      3:       c = 0.38268343236508977;
      4:       c = 0.98078528040323044;
      5:       c = 0.83146961230254524;
      6:       c = 0.55557023301960222;
      7:       c = 0.19509032201612826;
      default: c = 0.0;
    endcase
    mag = int'(0.5 * c * (2.0 ** FRAC_W));
    return (code < 0) ? -mag : mag;
  endfunction

  function automatic int romEntry(int k, int idx);
    int s = 0;
    for (int j = 0; j < LANE_IN; j++)
      if (((idx >> j) & 1) != 0) s += qConst(laneConst(k, j));
    return s;
  endfunction

  // Butterfly
  logic signed [TERM_W-1:0] xe   [NPT];
  logic signed [TERM_W-1:0] bfly [NPT];
  logic signed [TERM_W-1:0] shReg[NPT];

  for (genvar n = 0; n < NPT; n++) begin : g_ext
    assign xe[n] = TERM_W'(signed'(samples[n*DATA_W +: DATA_W]));
  end

  always_comb begin
    bfly[0] = xe[0] + xe[1] + xe[2] + xe[3] + xe[4] + xe[5] + xe[6] + xe[7];
    bfly[1] = xe[0] - xe[1] - xe[2] + xe[3] + xe[4] - xe[5] - xe[6] + xe[7];
    bfly[2] = xe[0] - xe[7];
    bfly[3] = xe[1] - xe[6];
    bfly[4] = xe[2] - xe[5];
    bfly[5] = xe[3] - xe[4];
    bfly[6] = xe[0] - xe[3] - xe[4] + xe[7];
    bfly[7] = xe[1] - xe[2] - xe[5] + xe[6];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NPT; i++) shReg[i] <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < NPT; i++) shReg[i] <= bfly[i];
    end else if (ctl.step) begin
      for (int i = 0; i < NPT; i++) shReg[i] <= shReg[i] >>> 1;
    end
  end

  // One distributed-arithmetic lane per coefficient
  for (genvar k = 0; k < NPT; k++) begin : g_lane
    logic signed [ROM_W-1:0] rom [ROM_N];
    logic [LANE_IN-1:0]      addr;
    logic signed [ROM_W-1:0] romSel;
    logic signed [ACC_W-1:0] addend;
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] accRnd;
    logic signed [OUT_W-1:0] coefQ;

    for (genvar a = 0; a < ROM_N; a++) begin : g_ent
      assign rom[a] = ROM_W'(romEntry(k, a));
    end

    always_comb begin
      for (int j = 0; j < LANE_IN; j++) addr[j] = shReg[laneTerm(k, j)][0];
    end

    assign romSel = rom[addr];

    always_comb begin
      addend = ACC_W'(romSel);
      if (ctl.lastBit) addend = -addend;
      addend = addend <<< (TERM_W - 1);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          acc <= '0;
      else if (ctl.load)  acc <= '0;
      else if (ctl.step)  acc <= (acc >>> 1) + addend;
    end

    assign accRnd = acc + ROUND_ADD;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            coefQ <= '0;
      else if (ctl.capture) coefQ <= accRnd[FRAC_W +: OUT_W];
    end

    assign coefs[k*OUT_W +: OUT_W] = coefQ;
  end

endmodule

// File: rtl/dct8_da.sv
module dct8_da
  import dct8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int FRAC_W = 12,
  parameter int TERM_W = DATA_W + 3,
  parameter int OUT_W  = TERM_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NPT*DATA_W-1:0] samples,
  output logic                  done,
  output logic [NPT*OUT_W-1:0]  coefs
);

  dct8_ctl_t ctl;

  dct8_ctrl #(.TERM_W(TERM_W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctl   (ctl),
    .done  (done)
  );

  dct8_datapath #(
    .DATA_W (DATA_W),
    .TERM_W (TERM_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .samples (samples),
    .coefs   (coefs)
  );

endmodule

// File: rtl/dct8_chk.sv
module dct8_chk #(
  parameter int TERM_W = 11,
  parameter int OUT_W  = 11
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               done,
  input logic [8*OUT_W-1:0] coefs
);

  localparam int DONE_AT = TERM_W + 2;
  localparam int WIN_W   = $clog2(DONE_AT + 1);

  logic [WIN_W-1:0] winCnt;
  logic             idleNow;

  assign idleNow = (winCnt == '0) || (winCnt == WIN_W'(DONE_AT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 winCnt <= '0;
    else if (idleNow && start) winCnt <= WIN_W'(1);
    else if (!idleNow)         winCnt <= winCnt + 1'b1;
    else                       winCnt <= '0;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winCnt == WIN_W'(DONE_AT)) |-> done);

  // R7
  done_only_due_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (winCnt == WIN_W'(DONE_AT)));

  // R6
  coef_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(coefs));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!done && coefs == '0));

endmodule

bind dct8_da dct8_chk #(.TERM_W(TERM_W), .OUT_W(OUT_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .done  (done),
  .coefs (coefs)
);

// File: tb/sim_dct8_da.sv
`timescale 1ns/1ps
module sim_dct8_da;

  localparam int DW  = 8;
  localparam int OW  = 11;
  localparam int LAT = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [63:0]   samples = '0;
  logic          done;
  logic [87:0]   coefs;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit ended  = 0;

  int          dueQ[$];
  logic [63:0] xQ[$];
  int          flagQ[$];
  logic [87:0] lastCoefs = '0;

  dct8_da u0 (.clk(clk), .rstN(rstN), .start(start), .samples(samples),
              .done(done), .coefs(coefs));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic real refF(logic [63:0] x, int k);
    real s = 0.0;
    for (int n = 0; n < 8; n++)
      s += real'($signed(x[n*DW +: DW])) *
           $cos(real'((2*n + 1) * k) * 3.14159265358979323846 / 16.0);
    return s * ((k == 0) ? 0.5 / $sqrt(2.0) : 0.5);
  endfunction

  // Driver: called at a falling edge, returns at the falling edge after acceptance.
  task automatic runOne(logic [63:0] x, int flag);
    samples = x;
    start   = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dueQ.push_back(cyc + LAT);
    xQ.push_back(x);
    flagQ.push_back(flag);
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && done) begin
      if (dueQ.size() == 0) begin
        check(0, "R7", "done with no accepted request", 1, 0);
      end else begin
        int due, flag, act, expI, bad;
        logic [63:0] x;
        string req;
        due = dueQ.pop_front(); x = xQ.pop_front(); flag = flagQ.pop_front();
        check(cyc == due, "R5", "done edge count", cyc, due);
        bad = 0;
        for (int k = 0; k < 8; k++) begin
          act  = $signed(coefs[k*OW +: OW]);
          expI = int'(refF(x, k));
          if (k == 0) req = "R1";
          else if (k == 4) req = "R2";
          else if (k == 2 || k == 6) req = "R3";
          else req = "R4";
          if (act > expI + 1 || act < expI - 1) bad++;
          check(act <= expI + 1 && act >= expI - 1, req,
                $sformatf("coef %0d", k), act, expI);
        end
        if (flag == 1) check(bad == 0, "R9", "full-scale vector mismatches", bad, 0);
        if (flag == 2) check(bad == 0, "R7", "result after ignored start", bad, 0);
        if (flag == 3) check(bad == 0, "R10", "back-to-back result", bad, 0);
        lastCoefs = coefs;
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    check(0, "R5", "watchdog expired", cyc, 0);
    finishRun();
  end

  function automatic logic [63:0] fill(int a, int b);
    logic [63:0] v;
    for (int n = 0; n < 8; n++) v[n*DW +: DW] = (n % 2 == 0) ? DW'(a) : DW'(b);
    return v;
  endfunction

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(done == 1'b0, "R8", "done during reset", done, 0);
    check(coefs == '0, "R8", "coefs during reset", (coefs != '0), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && coefs == '0, "R8", "idle after reset", (coefs != '0) || done, 0);

    runOne('0, 0); waitDone();
    @(negedge clk);
    runOne(fill(127, 127), 1);    waitDone(); @(negedge clk);
    runOne(fill(-128, -128), 1);  waitDone(); @(negedge clk);
    runOne(fill(127, -128), 1);   waitDone(); @(negedge clk);
    runOne(fill(-128, 127), 1);   waitDone(); @(negedge clk);
    runOne(64'h0000_0000_0000_0064, 0); waitDone(); @(negedge clk);
    for (int n = 0; n < 8; n++) v[n*DW +: DW] = DW'(n * 30 - 100);
    runOne(v, 0); waitDone(); @(negedge clk);

    for (int t = 0; t < 20; t++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      v[31:0] = seed;
      seed = seed * 32'd1103515245 + 32'd12345;
      v[63:32] = seed;
      runOne(v, 0); waitDone(); @(negedge clk);
    end

    // R7: start during computation is ignored
    runOne(64'h11F0_8040_7F01_C3A5, 2);
    repeat (3) @(negedge clk);
    samples = fill(-77, 55); start = 1'b1;
    @(negedge clk); start = 1'b0;
    waitDone();

    // R6: hold while samples change and no start
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      samples = {samples[62:0], ~samples[63]};
    end
    check(coefs == lastCoefs, "R6", "coefs held between pulses", (coefs != lastCoefs), 0);
    check(done == 1'b0, "R7", "no extra done after ignored start", done, 0);

    // R10: back-to-back
    runOne(fill(90, -30), 0);
    waitDone();
    runOne(64'h8080_7F7F_8080_7F7F, 3);
    waitDone();
    @(negedge clk);
    runOne(fill(5, -5), 3);
    waitDone();

    repeat (5) @(negedge clk);
    check(dueQ.size() == 0, "R5", "requests without result", dueQ.size(), 0);
    finishRun();
  end

endmodule